// File: doc/BRIEF.md
# Receive Call-Status Detect and Interrupt Unit

This unit watches the receive-side condition levels of a data link front end and keeps a five-bit detect word. Four of the conditions arrive as clean digital levels from upstream analog detectors: carrier present, call-progress tone, answer tone and weak-signal (long loop). The fifth, unscrambled mark, is made here. A run timer counts 1 kHz ticks while the raw demodulated data, taken before the descrambler, stays high. When the run is long enough, the timer declares the mark condition.

Every change in a condition, rising or falling, updates its detect bit. Every change except a change in long loop also sets a pending flag. The pending flag drives a level interrupt that the host can mask with an enable input. The host acknowledges by reading the detect word, which clears the flag. The detect word has no write path, so only the detection logic can change it.

Top module: `call_status_detect`

## Requirements
- R1: After a synchronous reset, `det_word` is all zeros and `irq` is low.
- R2: The `det_word` bit positions are: bit 0 carrier, bit 1 call-progress tone, bit 2 answer tone, bit 3 long loop, bit 4 unscrambled mark. Bits 0 to 3 take the new level of their input on the second rising clock edge after the input changes.
- R3: A change in either direction on bit 0, 1, 2 or 4 of `det_word` sets the pending flag on the same edge that updates the bit. With `irq_en` high, `irq` rises on that same edge.
- R4: A change in long loop updates bit 3 but never sets the pending flag or raises `irq`.
- R5: While `irq_en` is low, `irq` is low. A pending event is kept, and `irq` rises on the first edge after `irq_en` returns high.
- R6: A one-cycle `det_rd` pulse with no new event clears the pending flag and `irq` on that edge. It leaves `det_word` unchanged.
- R7: A condition change that lands on the same edge as a `det_rd` pulse leaves the pending flag set, so `irq` stays high.
- R8: Bit 4 sets once `MARK_TICKS` (default 166) ticks of `tick_1k` have been counted with the raw data continuously high. After `MARK_TICKS`-1 ticks it is still clear.
- R9: A single low sample of the raw data resets the run count to zero, so an interrupted run needs a full `MARK_TICKS` ticks again.
- R10: After unscrambled mark is detected, the first low raw-data sample clears bit 4 within three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | One-cycle 1 kHz timing enable |
| carrier_in | input | 1 | Carrier present level |
| cp_tone_in | input | 1 | Call-progress tone level |
| ans_tone_in | input | 1 | Answer tone level |
| long_loop_in | input | 1 | Weak received signal level |
| raw_data_in | input | 1 | Demodulated data before descrambling |
| irq_en | input | 1 | Interrupt enable, 0 masks `irq` |
| det_rd | input | 1 | Host read strobe of the detect word; acknowledges the interrupt |
| det_word | output | 5 | Read-only detect word |
| irq | output | 1 | Level interrupt request |

## Verification
The bench stops the mark run one tick short of the limit and then finishes it. An off-by-one timer would declare early or late. It also breaks a long run with a single low cycle; a design that paused the count instead of clearing it would declare mark too soon. The bench lands a carrier change on the exact edge of a read acknowledge; a design where the acknowledge wins would drop the interrupt and lose the event. Long-loop toggles and a masked-then-unmasked event show whether the interrupt takes in the excluded condition or forgets an event that arrived while masked.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int NUM_COND     = 5;
  localparam int IDX_CARRIER  = 0;
  localparam int IDX_CPTONE   = 1;
  localparam int IDX_ANSTONE  = 2;
  localparam int IDX_LONGLOOP = 3;
  localparam int IDX_MARK     = 4;
  // conditions that may raise the interrupt: all but long loop
  localparam logic [NUM_COND-1:0] IRQ_SOURCES = 5'b10111;
endpackage

// File: rtl/csd_sampler.sv
module csd_sampler #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/csd_mark_timer.sv
module csd_mark_timer #(
  parameter int MARK_TICKS = 166
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic data_q,
  output logic mark
);
  localparam int CW = $clog2(MARK_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MARK_TICKS);

  logic [CW-1:0] run_cnt;

  // counts ticks while high, saturates at LIMIT, any low sample restarts
  always_ff @(posedge clk) begin
    if (rst || !data_q)
      run_cnt <= '0;
    else if (tick && run_cnt != LIMIT)
      run_cnt <= run_cnt + 1'b1;
  end

  assign mark = (run_cnt == LIMIT);

  assert_run_restart_R9: assert property (@(posedge clk) disable iff (rst)
    !data_q |=> (run_cnt == '0));
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LIMIT);
  assert_mark_drop_R10: assert property (@(posedge clk) disable iff (rst)
    !data_q |=> !mark);
  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (data_q && !tick) |=> $stable(run_cnt));
endmodule

// File: rtl/csd_irq_ctrl.sv
module csd_irq_ctrl #(
  parameter int W = 5,
  parameter logic [W-1:0] SOURCES = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         ack,
  input  logic         en,
  output logic         irq
);
  logic pend_q;
  logic pend_d;
  logic hit;

  assign hit    = |(ev & SOURCES);
  // a new event on the acknowledge edge wins over the clear
  assign pend_d = (pend_q && !ack) || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq    <= pend_d && en;
    end
  end

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend_q);
  assert_ack_race_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && hit) |=> pend_q);
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> (!pend_q && !irq));
  assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !hit) |=> !pend_q);
endmodule

// File: rtl/call_status_detect.sv
module call_status_detect #(
  parameter int MARK_TICKS = 166
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1k,
  input  logic       carrier_in,
  input  logic       cp_tone_in,
  input  logic       ans_tone_in,
  input  logic       long_loop_in,
  input  logic       raw_data_in,
  input  logic       irq_en,
  input  logic       det_rd,
  output logic [4:0] det_word,
  output logic       irq
);
  import csd_pkg::*;

  logic [NUM_COND-1:0] raw_vec;
  logic [NUM_COND-1:0] samp_q;
  logic [NUM_COND-1:0] cond_now;
  logic [NUM_COND-1:0] change;
  logic [NUM_COND-1:0] det_q;
  logic                mark;

  assign raw_vec[IDX_CARRIER]  = carrier_in;
  assign raw_vec[IDX_CPTONE]   = cp_tone_in;
  assign raw_vec[IDX_ANSTONE]  = ans_tone_in;
  assign raw_vec[IDX_LONGLOOP] = long_loop_in;
  assign raw_vec[IDX_MARK]     = raw_data_in;

  csd_sampler #(.W(NUM_COND)) u_sampler (
    .clk (clk),
    .rst (rst),
    .d   (raw_vec),
    .q   (samp_q)
  );

  csd_mark_timer #(.MARK_TICKS(MARK_TICKS)) u_mark (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_1k),
    .data_q (samp_q[IDX_MARK]),
    .mark   (mark)
  );

  // per-condition detect bit and change flag against its last value
  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    if (i == IDX_MARK) begin : g_mark
      assign cond_now[i] = mark;
    end else begin : g_level
      assign cond_now[i] = samp_q[i];
    end
    assign change[i] = cond_now[i] ^ det_q[i];
    always_ff @(posedge clk) begin
      if (rst) det_q[i] <= 1'b0;
      else     det_q[i] <= cond_now[i];
    end
  end

  csd_irq_ctrl #(.W(NUM_COND), .SOURCES(IRQ_SOURCES)) u_irq (
    .clk (clk),
    .rst (rst),
    .ev  (change),
    .ack (det_rd),
    .en  (irq_en),
    .irq (irq)
  );

  assign det_word = det_q;

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (det_q[3:0] == $past(samp_q[3:0])));
  assert_read_no_touch_R6: assert property (@(posedge clk) disable iff (rst)
    (det_rd && change == '0) |=> $stable(det_q));
endmodule

// File: tb/test_call_status_detect.sv
`timescale 1ns/1ps
module test_call_status_detect;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_1k, carrier_in, cp_tone_in, ans_tone_in, long_loop_in, raw_data_in;
  logic       irq_en, det_rd;
  logic [4:0] det_word;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  call_status_detect #(.MARK_TICKS(166)) i_call_status_detect (
    .clk(clk), .rst(rst), .tick_1k(tick_1k), .carrier_in(carrier_in),
    .cp_tone_in(cp_tone_in), .ans_tone_in(ans_tone_in),
    .long_loop_in(long_loop_in), .raw_data_in(raw_data_in),
    .irq_en(irq_en), .det_rd(det_rd), .det_word(det_word), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack();
    det_rd = 1'b1; cyc(1); det_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1k = 1'b1; cyc(1); tick_1k = 1'b0; cyc(1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick_1k = 0; carrier_in = 0; cp_tone_in = 0; ans_tone_in = 0;
    long_loop_in = 0; raw_data_in = 0; irq_en = 1; det_rd = 0;
    cyc(3); rst = 1'b0; cyc(2);
    check("R1 det_word", det_word, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_carrier();
    carrier_in = 1; cyc(1);
    check("R2 carrier not yet", det_word[0], 0);
    cyc(1);
    check("R2 carrier bit0", det_word, 5'b00001);
    check("R3 irq on rise", irq, 1);
    ack(); check("R6 irq cleared", irq, 0);
    check("R6 det_word kept", det_word, 5'b00001);
    carrier_in = 0; cyc(2);
    check("R3 irq on fall", irq, 1);
    check("R2 carrier cleared", det_word, 0);
    ack();
  endtask

  task automatic t_tones();
    cp_tone_in = 1; cyc(2);
    check("R2 cp bit1", det_word, 5'b00010);
    check("R3 cp irq", irq, 1);
    ack();
    ans_tone_in = 1; cyc(2);
    check("R2 answer bit2", det_word, 5'b00110);
    check("R3 answer irq", irq, 1);
    ack(); cp_tone_in = 0; ans_tone_in = 0; cyc(2); ack();
    check("R6 clear after tones", irq, 0);
  endtask

  task automatic t_long_loop();
    long_loop_in = 1; cyc(3);
    check("R4 bit3 set", det_word, 5'b01000);
    check("R4 no irq rise", irq, 0);
    long_loop_in = 0; cyc(3);
    check("R4 bit3 clear", det_word, 0);
    check("R4 no irq fall", irq, 0);
  endtask

  task automatic t_mask();
    irq_en = 0; cp_tone_in = 1; cyc(3);
    check("R5 masked", irq, 0);
    irq_en = 1; cyc(1);
    check("R5 kept after unmask", irq, 1);
    ack(); cp_tone_in = 0; cyc(2); ack();
  endtask

  task automatic t_collide();
    carrier_in = 1; cyc(2);
    check("R7 pre pending", irq, 1);
    carrier_in = 0; cyc(1);
    ack();
    check("R7 event kept on ack edge", irq, 1);
    ack();
    check("R7 later ack clears", irq, 0);
  endtask

  task automatic t_mark_exact();
    raw_data_in = 1; cyc(1);
    ticks(165); cyc(2);
    check("R8 not at 165", det_word[4], 0);
    check("R8 no irq at 165", irq, 0);
    ticks(1); cyc(1);
    check("R8 mark at 166", det_word[4], 1);
    check("R8 mark irq", irq, 1);
    ack();
    raw_data_in = 0; cyc(3);
    check("R10 mark drops", det_word[4], 0);
    check("R10 drop irq", irq, 1);
    ack();
  endtask

  task automatic t_mark_broken();
    raw_data_in = 1; cyc(1);
    ticks(100);
    raw_data_in = 0; cyc(1); raw_data_in = 1; cyc(1);
    ticks(100); cyc(2);
    check("R9 broken run no mark", det_word[4], 0);
    ticks(66); cyc(2);
    check("R9 full run after break", det_word[4], 1);
    ack(); raw_data_in = 0; cyc(3); ack();
  endtask

  initial begin
    t_reset();
    t_carrier();
    t_tones();
    t_long_loop();
    t_mask();
    t_collide();
    t_mark_exact();
    t_mark_broken();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule